// File: doc/BRIEF.md
# Mode-Aware GPIO Port with Multiplexed Bus Takeover

This block is an 8-bit general-purpose I/O port. Its two registers (an output latch and a per-pin direction mask) appear in the on-chip register space only while the device runs in single-chip operation. In that mode, software sets pin directions and output levels. A read of the latch offset returns live pin levels for the input bits and latched values for the output bits.

In the three bus modes (narrow expanded, wide expanded, peripheral), both registers drop out of the register space. Accesses to their offsets raise an external-access strobe and leave the register contents alone. The pins are then reused as a time-multiplexed upper address and data byte, selected by a phase input. In narrow expanded mode, a byte-select input picks which half of the 16-bit data word goes out during the data phase.

Every output of the block is registered. A change on the inputs appears at the outputs one clock later.

Top module: `gpio_busmux_port`

## Requirements
- R1: The output latch is at register offset 0x00 and the direction mask at offset 0x02. A read of any other offset returns 0x00, and a write to any other offset changes neither register.
- R2: In single-chip mode (mode code 0), `pin_oe` equals the direction mask and `pin_out` equals the output latch, one cycle after the register holds its new value. A direction bit of 1 means output and 0 means high-impedance input.
- R3: Reset clears the direction mask to zero, so every `pin_oe` bit is 0 after reset. The output latch keeps its contents through reset.
- R4: In single-chip mode, a read of offset 0x00 returns, one cycle later, the latch bit for each output bit and the `pin_in` bit for each input bit.
- R5: In the bus modes (mode codes 1 narrow, 2 wide, 3 peripheral), writes to offsets 0x00 and 0x02 change neither register.
- R6: `ext_acc` is 1 in the cycle after an access (`reg_sel`=1) to offset 0x00 or 0x02 while the mode is not single-chip. It is 0 after any other access and after any cycle without an access.
- R7: In the wide and peripheral modes, `pin_out` carries `bus_addr[15:8]` when `bus_phase`=0 (address phase) and `bus_wdata[15:8]` when `bus_phase`=1 (data phase), one cycle later.
- R8: In narrow mode, the address phase drives `bus_addr[15:8]`. The data phase drives `bus_wdata[15:8]` when `byte_hi`=1 and `bus_wdata[7:0]` when `byte_hi`=0.
- R9: In every bus mode, `pin_oe` is all ones during the address phase and equals `bus_wr` replicated to all bits during the data phase. The direction mask has no effect on `pin_oe` in these modes.
- R10: In the bus modes, a register access returns `reg_rdata` = 0x00 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 single-chip, 1 narrow expanded, 2 wide expanded, 3 peripheral |
| bus_phase | input | 1 | 0 address phase, 1 data phase |
| byte_hi | input | 1 | Narrow data phase: 1 selects the high data byte, 0 the low byte |
| bus_wr | input | 1 | Bus cycle is a write (pins drive data) |
| bus_addr | input | 16 | Bus address word |
| bus_wdata | input | 16 | Bus write data word |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ext_acc | output | 1 | Registered strobe: access redirected off-chip |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |

## Verification
Register writes take effect at the clock edge where they are presented. `reg_rdata` and `ext_acc` are valid one edge after the access. `pin_out` and `pin_oe` follow a register change one edge later still, and follow mode, phase and bus inputs one edge after those inputs change. The bench drives inputs on the falling edge and samples on the next falling edge after the edge that produces the result. For pin checks that follow a register write, it waits one extra edge. The bench sweeps every mode, phase, byte select and write flag over a set of arithmetic bus patterns. It also sweeps direction masks and pin-input patterns, and computes each expected value from the requirement formulas.

// File: rtl/gbm_pkg.sv
package gbm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_PERIPH = 2'd3
  } port_mode_e;
endpackage

// File: rtl/gbm_regs.sv
module gbm_regs #(
  parameter int PORT_W   = 8,
  parameter int OFF_W    = 8,
  parameter int LAT_OFF  = 0,
  parameter int DIR_OFF  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_mode,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] lat_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] reg_rdata,
  output logic              ext_acc
);
  localparam logic [OFF_W-1:0] LAT_A = OFF_W'(LAT_OFF);
  localparam logic [OFF_W-1:0] DIR_A = OFF_W'(DIR_OFF);

  logic hit_lat, hit_dir, hit_any, wr_ok;
  logic [PORT_W-1:0] rd_mux;

  always_comb begin
    hit_lat = (reg_addr == LAT_A);
    hit_dir = (reg_addr == DIR_A);
    hit_any = hit_lat | hit_dir;
    wr_ok   = reg_sel & reg_we & ~bus_mode;
    rd_mux  = '0;
    if (!bus_mode) begin
      if (hit_lat) rd_mux = (dir_q & lat_q) | (~dir_q & pin_in);
      else if (hit_dir) rd_mux = dir_q;
    end
  end

  // output latch: deliberately not reset
  always_ff @(posedge clk) begin
    if (wr_ok && hit_lat) lat_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) dir_q <= '0;
    else if (wr_ok && hit_dir) dir_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      ext_acc   <= 1'b0;
    end else begin
      ext_acc <= reg_sel & hit_any & bus_mode;
      if (reg_sel) reg_rdata <= rd_mux;
    end
  end

  // R3
  dir_reset_chk: assert property (@(posedge clk) rst |=> (dir_q == '0));

  // R5
  bus_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_we && bus_mode) |=> ($stable(lat_q) && $stable(dir_q)));

  // R6
  ext_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && bus_mode && (reg_addr == LAT_A || reg_addr == DIR_A)) |=> ext_acc);

  // R6
  ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_sel || !bus_mode) |=> !ext_acc);
endmodule

// File: rtl/gbm_pinmux.sv
module gbm_pinmux
  import gbm_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int BUS_W = 2 * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  port_mode_e        mode,
  input  logic              bus_phase,
  input  logic              byte_hi,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [PORT_W-1:0] lat_q,
  input  logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic narrow, low_lane;
  logic [PORT_W-1:0] data_lane, nxt_out, nxt_oe;

  assign narrow   = (mode == MODE_NARROW);
  assign low_lane = narrow & ~byte_hi;

  for (genvar b = 0; b < PORT_W; b++) begin : g_lane
    assign data_lane[b] = low_lane ? bus_wdata[b] : bus_wdata[b + PORT_W];
  end

  always_comb begin
    if (mode == MODE_SINGLE) begin
      nxt_out = lat_q;
      nxt_oe  = dir_q;
    end else if (!bus_phase) begin
      nxt_out = bus_addr[BUS_W-1:PORT_W];
      nxt_oe  = '1;
    end else begin
      nxt_out = data_lane;
      nxt_oe  = {PORT_W{bus_wr}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
    end
  end

  // R9
  addr_phase_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != MODE_SINGLE && !$past(bus_phase)) |-> (pin_oe == '1));

  // R7
  addr_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != MODE_SINGLE && !$past(bus_phase))
      |-> (pin_out == $past(bus_addr[BUS_W-1:PORT_W])));
endmodule

// File: rtl/gpio_busmux_port.sv
module gpio_busmux_port
  import gbm_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int OFF_W   = 8,
  parameter int LAT_OFF = 0,
  parameter int DIR_OFF = 2,
  localparam int BUS_W  = 2 * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              bus_phase,
  input  logic              byte_hi,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  output logic              ext_acc,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  port_mode_e mode_e;
  logic bus_mode;
  logic [PORT_W-1:0] lat_q, dir_q;

  assign mode_e   = port_mode_e'(mode);
  assign bus_mode = (mode_e != MODE_SINGLE);

  gbm_regs #(
    .PORT_W(PORT_W), .OFF_W(OFF_W), .LAT_OFF(LAT_OFF), .DIR_OFF(DIR_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_mode(bus_mode),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pin_in(pin_in),
    .lat_q(lat_q), .dir_q(dir_q),
    .reg_rdata(reg_rdata), .ext_acc(ext_acc)
  );

  gbm_pinmux #(.PORT_W(PORT_W)) u_mux (
    .clk(clk), .rst(rst), .mode(mode_e),
    .bus_phase(bus_phase), .byte_hi(byte_hi), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .lat_q(lat_q), .dir_q(dir_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R2
  single_oe_follows_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_e) == MODE_SINGLE) |-> (pin_oe == $past(dir_q)));

  // R10
  bus_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && bus_mode) |=> (reg_rdata == '0));
endmodule

// File: tb/gpio_busmux_port_bench.sv
module gpio_busmux_port_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic bus_phase = 0, byte_hi = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic reg_sel = 0, reg_we = 0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, pin_in = '0;
  logic [7:0] reg_rdata, pin_out, pin_oe;
  logic ext_acc;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_busmux_port u_gpio_busmux_port (
    .clk(clk), .rst(rst), .mode(mode), .bus_phase(bus_phase), .byte_hi(byte_hi),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_acc(ext_acc), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [7:0] d);
    reg_sel = 1; reg_we = we; reg_addr = a; reg_wdata = d;
    tick();
    reg_sel = 0; reg_we = 0;
  endtask

  function automatic logic [15:0] exp_pins(input int m, input logic ph, input logic bh,
      input logic wr, input logic [15:0] ad, input logic [15:0] wd);
    logic [7:0] o, e;
    if (!ph) begin o = ad[15:8]; e = 8'hFF; end
    else begin
      o = (m == 1 && !bh) ? wd[7:0] : wd[15:8];
      e = {8{wr}};
    end
    return {o, e};
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] dv;
    @(negedge clk); tick(); tick();
    rst = 0;
    tick();
    // R3 reset state
    check("R3 oe after reset", pin_oe, 8'h00);
    check("R6 strobe idle", ext_acc, 1'b0);

    // R2 single-chip output
    acc(1, 8'h00, 8'hA5);
    acc(1, 8'h02, 8'hF0);
    tick();
    check("R2 oe", pin_oe, 8'hF0);
    check("R2 out", pin_out, 8'hA5);

    // R4 mixed read sweep
    for (int i = 0; i < 16; i++) begin
      pin_in = 8'(i * 29 + 3);
      acc(0, 8'h00, 8'h00);
      check("R4 latch read", reg_rdata, (8'hF0 & 8'hA5) | (8'h0F & pin_in));
    end
    // R1 offsets
    acc(0, 8'h02, 8'h00);
    check("R1 dir read", reg_rdata, 8'hF0);
    acc(1, 8'h01, 8'h77);
    acc(1, 8'h03, 8'h77);
    acc(0, 8'h01, 8'h00);
    check("R1 other read", reg_rdata, 8'h00);
    acc(0, 8'h05, 8'h00);
    check("R1 other read 5", reg_rdata, 8'h00);
    acc(0, 8'h02, 8'h00);
    check("R1 dir untouched", reg_rdata, 8'hF0);
    tick();
    check("R1 latch untouched", pin_out, 8'hA5);

    // R2 direction sweep
    for (int i = 0; i < 16; i++) begin
      dv = 8'(i * 17);
      acc(1, 8'h02, dv);
      tick();
      check("R2 oe sweep", pin_oe, dv);
    end

    // R3 latch kept through reset
    acc(1, 8'h00, 8'h3C);
    acc(1, 8'h02, 8'hFF);
    rst = 1; tick(); rst = 0;
    tick();
    check("R3 dir cleared", pin_oe, 8'h00);
    check("R3 latch kept on pins", pin_out, 8'h3C);
    acc(1, 8'h02, 8'hFF);
    acc(0, 8'h00, 8'h00);
    check("R3 latch kept read", reg_rdata, 8'h3C);

    // R5 R6 R10 bus modes
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      acc(1, 8'h00, 8'h11);
      check("R6 strobe lat", ext_acc, 1'b1);
      acc(1, 8'h02, 8'h22);
      check("R6 strobe dir", ext_acc, 1'b1);
      acc(0, 8'h00, 8'h00);
      check("R10 bus read", reg_rdata, 8'h00);
      acc(0, 8'h04, 8'h00);
      check("R6 no strobe other", ext_acc, 1'b0);
      tick();
      check("R6 no strobe idle", ext_acc, 1'b0);
    end
    mode = 2'd0;
    acc(0, 8'h00, 8'h00);
    check("R6 no strobe single", ext_acc, 1'b0);
    check("R5 latch unchanged", reg_rdata, 8'h3C);
    acc(0, 8'h02, 8'h00);
    check("R5 dir unchanged", reg_rdata, 8'hFF);

    // R7 R8 R9 pin sweep (direction mask 0x5A must not matter)
    acc(1, 8'h02, 8'h5A);
    for (int m = 1; m < 4; m++)
      for (int ph = 0; ph < 2; ph++)
        for (int bh = 0; bh < 2; bh++)
          for (int wr = 0; wr < 2; wr++)
            for (int k = 0; k < 4; k++) begin
              logic [15:0] e;
              mode = 2'(m); bus_phase = 1'(ph); byte_hi = 1'(bh); bus_wr = 1'(wr);
              bus_addr = 16'(k * 4973 + m * 311 + 7);
              bus_wdata = 16'(k * 7919 + ph * 1021 + 40503);
              tick();
              e = exp_pins(m, 1'(ph), 1'(bh), 1'(wr), bus_addr, bus_wdata);
              check((m == 1) ? "R8 narrow out" : "R7 wide out", pin_out, e[15:8]);
              check("R9 oe", pin_oe, e[7:0]);
            end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule